// File: doc/BRIEF.md
# Way-Predicted Set-Associative Lookup Controller

This block is the hit path of a small set-associative cache. A predictor entry is kept for every set and names the way to try first. When a lookup is accepted, the predicted way's data is routed straight to the result and only that way's tag is compared. If that compare succeeds, the answer comes out after a single cycle. If it fails, the block stalls its request port, compares the tags of the remaining ways one cycle later, and then reports either a slow hit or a miss. A slow hit also retrains the predictor for that set.

A parameter selects a low-power way-selection variant. In this variant the predictor is used like an extra address bit: on the first try only the predicted way's arrays are read. After a misprediction the other ways' arrays must be read again in a separate cycle before they can be compared, so that path costs one cycle more. Refill sequencing, write policy and coherence are left to the surrounding logic. A miss is only reported, and a plain fill port writes one line into a chosen way. Four event counters report prediction accuracy.

The request port follows valid/ready rules. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a second-try lookup is in flight and in any cycle where a fill is offered, because a fill takes priority. A fill is taken on an edge where `fill_valid` and `fill_ready` are both high. The response is a single-cycle pulse with no back-pressure, and the consumer must take it in the cycle it appears.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, every line is invalid, every predictor selects way 0, all counters read 0, `busy` is low and `req_ready` is high, so a first lookup reports a miss.
- R2: When the predicted way holds a valid line with a matching tag, `resp_valid` pulses in the cycle after acceptance with `resp_hit`=1, `resp_fast`=1 and that line's data.
- R3: When the predicted way does not match but another way does, `busy` is high in the cycle after acceptance and the response shows `resp_hit`=1 and `resp_fast`=0 with the matching way's data. The response arrives two cycles after acceptance in normal mode. If several other ways match, the lowest-numbered one wins.
- R4: After a slow hit, the set's predictor points at the way that hit, so repeating the same lookup gives a fast hit.
- R5: When no way matches, the response shows `resp_hit`=0, `resp_fast`=0 and `resp_data`=0, and the set's predictor is left unchanged.
- R6: A fill writes the tag, data and valid bit of way `fill_way` in the set indexed by `fill_addr`, and points that set's predictor at `fill_way`.
- R7: `req_ready` is low while `busy` is high and while `fill_valid` is high. `fill_ready` is low while `busy` is high. A request offered together with a fill is not taken and produces no response.
- R8: With WAY_SEL=1, `arr_en` is one-hot on the predicted way in the acceptance cycle. After a miss on the first try, a re-read cycle follows with `arr_en` set for every other way. `busy` stays high for two cycles and the response arrives three cycles after acceptance.
- R9: With WAY_SEL=0, `arr_en` has every bit set in the acceptance cycle and is all zero during the second-try compare cycle.
- R10: `cnt_access` counts accepted requests, `cnt_fast` counts first-try hits, `cnt_slow` counts second-try hits and `cnt_miss` counts misses.
- R11: The set index is taken from address bits [OFF_W +: IDX_W], which are bits [4:2] by default, and the tag from the bits above them. Byte-offset bits [1:0] are ignored. Elaboration stops if OFF_W+IDX_W exceeds PAGE_BITS, which keeps the capacity within page size times associativity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_addr | input | ADDR_W | Lookup address |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_way | input | log2(WAYS) | Way to write |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_data | input | DATA_W | Data of the filled line |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Lookup hit |
| resp_fast | output | 1 | Hit on the first try |
| resp_data | output | DATA_W | Hit data, zero on a miss |
| busy | output | 1 | Second-try lookup in progress |
| arr_en | output | WAYS | Way arrays read in this cycle |
| cnt_access | output | CNT_W | Accepted lookups |
| cnt_fast | output | CNT_W | First-try hits |
| cnt_slow | output | CNT_W | Second-try hits |
| cnt_miss | output | CNT_W | Misses |

## Verification
The bench builds two copies and drives both with the same stimulus. One copy uses four ways in normal mode, which exercises the one-cycle second try and the lowest-way choice among several remaining ways. The other uses two ways with WAY_SEL=1, which exercises the one-hot first read and the extra re-read cycle. A small tag pool spread over eight sets forces frequent conflicts, mispredictions and retraining, and the bench checks the latency, the array enables and the final counter values of each copy against its own reference model.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REREAD = 2'd1,
    ST_CMP    = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wp_way_bank.sv
module wp_way_bank #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  // A disabled bank returns nothing, as if its arrays were not clocked.
  always_comb begin
    rd_valid = rd_en & vld_q[rd_idx];
    rd_tag   = rd_en ? tag_q[rd_idx] : '0;
    rd_data  = rd_en ? dat_q[rd_idx] : '0;
  end
endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] rd_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WAY_W-1:0] wr_way
);
  logic [WAY_W-1:0] way_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) way_q[s] <= '0;
    end else if (wr_en) begin
      way_q[wr_idx] <= wr_way;
    end
  end

  assign rd_way = way_q[rd_idx];
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wp_cache_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int SETS      = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 2,
  parameter int PAGE_BITS = 12,
  parameter int WAY_SEL   = 0,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(SETS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_fast,
  output logic [DATA_W-1:0] resp_data,
  output logic              busy,
  output logic [WAYS-1:0]   arr_en,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_fast,
  output logic [CNT_W-1:0]  cnt_slow,
  output logic [CNT_W-1:0]  cnt_miss
);
  // R11: the index must lie inside the page offset
  if (IDX_W + OFF_W > PAGE_BITS) begin : g_cap_check
    $error("index and offset bits exceed the page offset");
  end
  if (WAYS != 2 && WAYS != 4) begin : g_way_check
    $error("WAYS must be 2 or 4");
  end

  wp_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [WAY_W-1:0]  pred_q;
  logic [WAYS-1:0]   hold_val;
  logic [TAG_W-1:0]  hold_tag [WAYS];
  logic [DATA_W-1:0] hold_dat [WAYS];

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx, rd_idx, fill_idx;
  logic [WAY_W-1:0]  pred_way, slow_way, pred_wr_way;
  logic              accept, do_fill, fast_hit, pred_we;
  logic [WAYS-1:0]   b_val, slow_vec;
  logic [TAG_W-1:0]  b_tag [WAYS];
  logic [DATA_W-1:0] b_dat [WAYS];

  assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx    = req_addr[OFF_W +: IDX_W];
  assign fill_idx   = fill_addr[OFF_W +: IDX_W];
  assign busy       = (state_q != ST_IDLE);
  assign fill_ready = !busy;
  assign req_ready  = !busy && !fill_valid;
  assign accept     = req_valid && req_ready;
  assign do_fill    = fill_valid && fill_ready;
  assign rd_idx     = busy ? idx_q : req_idx;

  wp_pred_table #(.SETS(SETS), .WAYS(WAYS)) u_pred (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_way(pred_way),
    .wr_en(pred_we), .wr_idx(do_fill ? fill_idx : idx_q), .wr_way(pred_wr_way)
  );

  always_comb begin
    arr_en = '0;
    if (accept) begin
      if (WAY_SEL != 0) arr_en[pred_way] = 1'b1;
      else              arr_en = '1;
    end else if (state_q == ST_REREAD) begin
      arr_en = '1;
      arr_en[pred_q] = 1'b0;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(do_fill && (fill_way == WAY_W'(w))), .wr_idx(fill_idx),
      .wr_tag(fill_addr[ADDR_W-1 -: TAG_W]), .wr_data(fill_data),
      .rd_en(arr_en[w]), .rd_idx(rd_idx),
      .rd_valid(b_val[w]), .rd_tag(b_tag[w]), .rd_data(b_dat[w])
    );
    assign slow_vec[w] = (pred_q != WAY_W'(w)) && hold_val[w] && (hold_tag[w] == tag_q);
  end

  assign fast_hit = b_val[pred_way] && (b_tag[pred_way] == req_tag);

  always_comb begin
    slow_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (slow_vec[w]) slow_way = WAY_W'(w);
  end

  assign pred_we     = do_fill || (state_q == ST_CMP && |slow_vec);
  assign pred_wr_way = do_fill ? fill_way : slow_way;

  always_ff @(posedge clk) begin
    if (accept || state_q == ST_REREAD) begin
      for (int w = 0; w < WAYS; w++) begin
        if (arr_en[w]) begin
          hold_tag[w] <= b_tag[w];
          hold_dat[w] <= b_dat[w];
        end
      end
    end
    if (accept) begin
      idx_q  <= req_idx;
      tag_q  <= req_tag;
      pred_q <= pred_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hold_val   <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fast  <= 1'b0;
      resp_data  <= '0;
      cnt_access <= '0;
      cnt_fast   <= '0;
      cnt_slow   <= '0;
      cnt_miss   <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept || state_q == ST_REREAD) begin
        for (int w = 0; w < WAYS; w++) if (arr_en[w]) hold_val[w] <= b_val[w];
      end
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cnt_access <= cnt_access + 1'b1;
          if (fast_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_fast  <= 1'b1;
            resp_data  <= b_dat[pred_way];
            cnt_fast   <= cnt_fast + 1'b1;
          end else begin
            state_q <= (WAY_SEL != 0) ? ST_REREAD : ST_CMP;
          end
        end
        ST_REREAD: state_q <= ST_CMP;
        ST_CMP: begin
          state_q    <= ST_IDLE;
          resp_valid <= 1'b1;
          resp_fast  <= 1'b0;
          resp_hit   <= |slow_vec;
          resp_data  <= (|slow_vec) ? hold_dat[slow_way] : '0;
          if (|slow_vec) cnt_slow <= cnt_slow + 1'b1;
          else           cnt_miss <= cnt_miss + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_cache_lookup_chk.sv
module wp_cache_lookup_chk #(
  parameter int WAYS    = 4,
  parameter int DATA_W  = 32,
  parameter int WAY_SEL = 0,
  parameter int CNT_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_fast,
  input logic [DATA_W-1:0] resp_data,
  input logic              busy,
  input logic [WAYS-1:0]   arr_en,
  input logic [CNT_W-1:0]  cnt_access
);
  a_r2_fast_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fast |-> resp_hit);

  a_r3_slow_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fast |-> $past(busy));

  a_r3_one_stall_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (WAY_SEL == 0) && $rose(busy) |=> !busy);

  a_r8_two_stall_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (WAY_SEL != 0) && $rose(busy) |=> busy ##1 !busy);

  a_r8_single_way_read: assert property (@(posedge clk) disable iff (!rst_n)
    (WAY_SEL != 0) && req_valid && req_ready |-> $countones(arr_en) == 1);

  a_r5_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_data == '0);

  a_r10_access_count: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cnt_access == $past(cnt_access) + CNT_W'(1));

  a_r7_accept_progresses: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid || busy);
endmodule

bind wp_cache_lookup wp_cache_lookup_chk #(
  .WAYS(WAYS), .DATA_W(DATA_W), .WAY_SEL(WAY_SEL), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fast(resp_fast),
  .resp_data(resp_data), .busy(busy), .arr_en(arr_en), .cnt_access(cnt_access)
);

// File: tb/wp_cache_lookup_tb.sv
module wp_cache_lookup_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, fill_valid = 1'b0;
  logic [15:0] req_addr = '0, fill_addr = '0;
  logic [1:0]  fill_way = '0;
  logic [31:0] fill_data = '0;

  logic        rq[2], fr[2], rv[2], rh[2], rf[2], bz[2];
  logic [31:0] rd[2];
  logic [3:0]  ae0;
  logic [1:0]  ae1;
  logic [15:0] ca[2], cf[2], cs[2], cm[2];

  wp_cache_lookup #(.WAYS(4), .WAY_SEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rq[0]), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_ready(fr[0]), .fill_way(fill_way), .fill_addr(fill_addr),
    .fill_data(fill_data), .resp_valid(rv[0]), .resp_hit(rh[0]), .resp_fast(rf[0]),
    .resp_data(rd[0]), .busy(bz[0]), .arr_en(ae0), .cnt_access(ca[0]), .cnt_fast(cf[0]),
    .cnt_slow(cs[0]), .cnt_miss(cm[0]));

  wp_cache_lookup #(.WAYS(2), .WAY_SEL(1)) u_dut_ws (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rq[1]), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_ready(fr[1]), .fill_way(fill_way[0:0]), .fill_addr(fill_addr),
    .fill_data(fill_data), .resp_valid(rv[1]), .resp_hit(rh[1]), .resp_fast(rf[1]),
    .resp_data(rd[1]), .busy(bz[1]), .arr_en(ae1), .cnt_access(ca[1]), .cnt_fast(cf[1]),
    .cnt_slow(cs[1]), .cnt_miss(cm[1]));

  // reference model, index d: 0 = four-way normal, 1 = two-way way-selection
  logic        m_val[2][4][8];
  logic [10:0] m_tag[2][4][8];
  logic [31:0] m_dat[2][4][8];
  int          m_pred[2][8];
  int          e_acc[2], e_fast[2], e_slow[2], e_miss[2];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nways(input int d);
    return (d == 0) ? 4 : 2;
  endfunction

  task automatic do_fill(input int way, input logic [15:0] addr, input logic [31:0] data);
    @(negedge clk);
    fill_valid = 1'b1; fill_way = 2'(way); fill_addr = addr; fill_data = data;
    req_valid = 1'b1; req_addr = addr;
    #1;
    for (int d = 0; d < 2; d++) begin
      chk(rq[d] == 1'b0, "R7 req_ready low during fill", rq[d], 0);
      chk(fr[d] == 1'b1, "R7 fill_ready idle", fr[d], 1);
    end
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      int w = way % nways(d);
      chk(rv[d] == 1'b0, "R7 request with fill ignored", rv[d], 0);
      m_val[d][w][addr[4:2]] = 1'b1;
      m_tag[d][w][addr[4:2]] = addr[15:5];
      m_dat[d][w][addr[4:2]] = data;
      m_pred[d][addr[4:2]] = w;
    end
  endtask

  task automatic lookup(input logic [15:0] addr);
    int idx = int'(addr[4:2]);
    int lat[2], hw[2], p[2];
    bit eh[2];
    logic [31:0] ed[2];
    for (int d = 0; d < 2; d++) begin
      p[d] = m_pred[d][idx];
      eh[d] = 0; hw[d] = 0;
      if (m_val[d][p[d]][idx] && m_tag[d][p[d]][idx] == addr[15:5]) begin
        eh[d] = 1; hw[d] = p[d]; lat[d] = 1;
      end else begin
        lat[d] = (d == 0) ? 2 : 3;
        for (int w = nways(d) - 1; w >= 0; w--)
          if (w != p[d] && m_val[d][w][idx] && m_tag[d][w][idx] == addr[15:5]) begin
            eh[d] = 1; hw[d] = w;
          end
      end
      ed[d] = eh[d] ? m_dat[d][hw[d]][idx] : 32'h0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    #1;
    chk(rq[0] && rq[1], "R7 ready when idle", {rq[0], rq[1]}, 2'b11);
    chk(ae0 == 4'hF, "R9 all ways read on first try", ae0, 4'hF);
    chk(ae1 == 2'(1 << p[1]), "R8 only predicted way read", ae1, 2'(1 << p[1]));
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      for (int d = 0; d < 2; d++) begin
        chk(rv[d] == (c == lat[d]), "R2 R3 R8 response cycle", rv[d], c == lat[d]);
        chk(bz[d] == (c < lat[d]), "R3 R8 busy window", bz[d], c < lat[d]);
        if (bz[d]) chk(rq[d] == 1'b0, "R7 req_ready low while busy", rq[d], 0);
        if (c == lat[d]) begin
          chk(rh[d] == eh[d], "R3 R5 hit flag", rh[d], eh[d]);
          chk(rf[d] == (lat[d] == 1), "R2 R3 fast flag", rf[d], lat[d] == 1);
          chk(rd[d] == ed[d], "R2 R3 R5 data", rd[d], ed[d]);
        end
      end
      if (c == 1 && lat[0] == 2) chk(ae0 == 4'h0, "R9 no array read in compare", ae0, 0);
      if (c == 1 && lat[1] == 3)
        chk(ae1 == ~2'(1 << p[1]), "R8 re-read other way", ae1, ~2'(1 << p[1]));
      if (c < 3) @(negedge clk);
    end
    for (int d = 0; d < 2; d++) begin
      e_acc[d]++;
      if (lat[d] == 1) e_fast[d]++;
      else if (eh[d]) begin e_slow[d]++; m_pred[d][idx] = hw[d]; end
      else e_miss[d]++;
    end
  endtask

  function automatic logic [15:0] mk(input int tag, input int idx);
    return {11'(tag), 3'(idx), 2'b00};
  endfunction

  initial begin
    int seed;
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 8; s++) begin
        m_pred[d][s] = 0;
        for (int w = 0; w < 4; w++) begin
          m_val[d][w][s] = 0; m_tag[d][w][s] = '0; m_dat[d][w][s] = '0;
        end
      end
      e_acc[d] = 0; e_fast[d] = 0; e_slow[d] = 0; e_miss[d] = 0;
    end
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(bz[d] == 0 && rq[d] == 1, "R1 idle after reset", {bz[d], rq[d]}, 2'b01);
      chk((ca[d] | cf[d] | cs[d] | cm[d]) == 0, "R1 counters zero", ca[d], 0);
    end
    lookup(mk(3, 5));                       // R1 cold miss
    do_fill(0, mk(1, 1), 32'hA1A1_0001);    // R6
    lookup(mk(1, 1));                       // R2 fast
    lookup(mk(1, 1) | 16'h3);               // R11 byte offset ignored
    do_fill(1, mk(2, 1), 32'hB2B2_0002);    // predictor -> way 1
    lookup(mk(1, 1));                       // R3 slow hit
    lookup(mk(1, 1));                       // R4 retrained, fast
    lookup(mk(4, 1));                       // R5 miss
    lookup(mk(1, 1));                       // R5 predictor kept
    do_fill(3, mk(5, 2), 32'hC3C3_0003);
    do_fill(2, mk(6, 2), 32'hD4D4_0004);
    lookup(mk(5, 2));
    lookup(mk(6, 2));
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 99));
      logic [15:0] a = mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 7)));
      if (r < 30) do_fill(int'($urandom_range(0, 3)), a, $urandom);
      else lookup(a);
    end
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(ca[d] == 16'(e_acc[d]), "R10 access count", ca[d], e_acc[d]);
      chk(cf[d] == 16'(e_fast[d]), "R10 fast count", cf[d], e_fast[d]);
      chk(cs[d] == 16'(e_slow[d]), "R10 slow count", cs[d], e_slow[d]);
      chk(cm[d] == 16'(e_miss[d]), "R10 miss count", cm[d], e_miss[d]);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule